// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block brings an LCD panel's controller up and down by driving a serial register writer. Each write is a transaction: a register address, followed by zero, one or two data bytes. The sequencer hands one transaction at a time to the writer. It waits for the writer's completion pulse before it moves on to the next one, and it notes whether that transaction failed.

When an enable request arrives while the panel is off, the block sends several wake-up commands with a programmable pause after each. It then checks whether any of them failed. If none did, it walks a fixed configuration list held in an internal table. The last entry in that list switches the display on, and the block then reports the panel as active. A disable request while the panel is active runs a short shutdown list and then reports the panel as off.

Failures that occur after the wake-up phase do not stop the sequence. They are collected and reported when the sequence ends.

Top module: `panel_power_seq`

## Requirements
- R1: After reset, `panel_active`, `seq_error` and `tx_start` are all 0.
- R2: An enable request while off first issues `WAKE_WRITES` (default 3) command-only writes of register 0x00 (`tx_nbytes`=0). After the completion of each of these, at least `WAKE_DLY_CYC` clock cycles pass before the next write is started.
- R3: `tx_start` is a one-cycle pulse. No new transaction starts before `tx_done` of the previous one. `tx_reg`, `tx_nbytes` and `tx_payload` hold steady while a transaction is outstanding.
- R4: If any wake-up write completes with `tx_fail`=1, no configuration write follows. The panel stays off, and `seq_error` becomes 1.
- R5: The configuration list is written in a fixed order. It begins with 0xB0/0x17, 0xBC/0x80, 0x3B/0x00 and 0xB0/0x16. These are followed by 0xB8 with the two-byte value 0xFFF9 and then the command-only 0x11. The list includes 0xBD/0x04 and ends with the command-only 0x29, 41 writes in all. `tx_nbytes` encodes 0, 1 or 2 data bytes. A single byte sits in `tx_payload[7:0]`, and a two-byte value uses all 16 bits with the upper byte sent first.
- R6: `panel_active` rises only in the cycle after the completion of the 0x29 write, and never earlier.
- R7: A failed write after the wake-up phase does not stop the sequence. The whole list is still written, the panel becomes active, and `seq_error` is 1 at the end.
- R8: A disable request while active writes, in this order: 0x28 (no data), 0xB8/0x8002 (two bytes), 0x10 (no data) and 0xB0/0x00 (one byte). After that, `panel_active` falls to 0.
- R9: The following requests start no write and leave `panel_active` unchanged: an enable request while active, a disable request while off, and any request while a sequence is running.
- R10: `seq_error` is updated at the end of each sequence, to the OR of that sequence's failures. A clean sequence therefore clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Power-up request pulse |
| dis_req | input | 1 | Power-down request pulse |
| tx_start | output | 1 | Starts one writer transaction |
| tx_reg | output | 8 | Register address of the transaction |
| tx_nbytes | output | 2 | Number of data bytes (0, 1 or 2) |
| tx_payload | output | 16 | Data value (one byte in [7:0]) |
| tx_done | input | 1 | Writer completion pulse |
| tx_fail | input | 1 | Writer failure flag, valid with `tx_done` |
| panel_active | output | 1 | 1 while the panel is powered and on |
| seq_error | output | 1 | Failure summary of the last sequence |

## Verification
The checks assume that the writer raises `tx_done` for exactly one cycle per started transaction, never without an outstanding one, and that `tx_fail` is meaningful only in that cycle. The bench's writer model keeps to this contract. It answers every start after a fixed latency, with a single-cycle completion, and it injects a failure only on a chosen transaction index. Requests are single-cycle pulses driven between clock edges. Some of them fall deliberately inside a running sequence, to show that they are ignored.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

   localparam int UP_LEN  = 41;
   localparam int DN_LEN  = 4;
   localparam int TBL_LEN = UP_LEN + DN_LEN;
   localparam int DN_BASE = UP_LEN;
   localparam int IDX_W   = $clog2(TBL_LEN);

   typedef struct packed {
      logic [7:0]  reg_addr;
      logic [1:0]  nbytes;
      logic [15:0] value;
   } seq_entry_t;

   typedef enum logic [3:0] {
      S_OFF, S_WK_ISSUE, S_WK_WAIT, S_WK_DLY,
      S_UP_ISSUE, S_UP_WAIT, S_ON, S_DN_ISSUE, S_DN_WAIT
   } seq_state_t;

   function automatic seq_entry_t mk(input logic [7:0] r, input logic [1:0] n,
                                     input logic [15:0] v);
      seq_entry_t e;
      e.reg_addr = r;
      e.nbytes   = n;
      e.value    = v;
      return e;
   endfunction

   // Power-up list (0..40) then power-down list (41..44); order is behaviour.
   function automatic seq_entry_t seq_lookup(input logic [IDX_W-1:0] i);
      case (i)
         6'd0:  return mk(8'hB0, 2'd1, 16'h0017);
         6'd1:  return mk(8'hBC, 2'd1, 16'h0080);
         6'd2:  return mk(8'h3B, 2'd1, 16'h0000);
         6'd3:  return mk(8'hB0, 2'd1, 16'h0016);
         6'd4:  return mk(8'hB8, 2'd2, 16'hFFF9);
         6'd5:  return mk(8'h11, 2'd0, 16'h0000);
         6'd6:  return mk(8'hBA, 2'd1, 16'h0001);
         6'd7:  return mk(8'hBB, 2'd1, 16'h0000);
         6'd8:  return mk(8'h3A, 2'd1, 16'h0060);
         6'd9:  return mk(8'hBF, 2'd1, 16'h0010);
         6'd10: return mk(8'hB1, 2'd1, 16'h0056);
         6'd11: return mk(8'hB2, 2'd1, 16'h0033);
         6'd12: return mk(8'hB3, 2'd1, 16'h0011);
         6'd13: return mk(8'hB3, 2'd1, 16'h0011);
         6'd14: return mk(8'hB4, 2'd1, 16'h0002);
         6'd15: return mk(8'hB5, 2'd1, 16'h002B);
         6'd16: return mk(8'hB6, 2'd1, 16'h0040);
         6'd17: return mk(8'hB7, 2'd1, 16'h0003);
         6'd18: return mk(8'hB9, 2'd1, 16'h0004);
         6'd19: return mk(8'hBD, 2'd1, 16'h0004);
         6'd20: return mk(8'hBE, 2'd1, 16'h0000);
         6'd21: return mk(8'hC0, 2'd1, 16'h0011);
         6'd22: return mk(8'hC1, 2'd1, 16'h0011);
         6'd23: return mk(8'hC2, 2'd1, 16'h0011);
         6'd24: return mk(8'hC3, 2'd2, 16'h2040);
         6'd25: return mk(8'hC4, 2'd2, 16'h60C0);
         6'd26: return mk(8'hC5, 2'd2, 16'h1020);
         6'd27: return mk(8'hC6, 2'd2, 16'h60C0);
         6'd28: return mk(8'hC7, 2'd2, 16'h5533);
         6'd29: return mk(8'hC8, 2'd1, 16'h0000);
         6'd30: return mk(8'hC9, 2'd1, 16'h0000);
         6'd31: return mk(8'hCA, 2'd1, 16'h0000);
         6'd32: return mk(8'hEC, 2'd2, 16'h01F0);
         6'd33: return mk(8'hCF, 2'd1, 16'h0002);
         6'd34: return mk(8'hD0, 2'd2, 16'h0804);
         6'd35: return mk(8'hD1, 2'd1, 16'h0001);
         6'd36: return mk(8'hD2, 2'd2, 16'h0000);
         6'd37: return mk(8'hD3, 2'd2, 16'h0D0E);
         6'd38: return mk(8'hD4, 2'd2, 16'h11A4);
         6'd39: return mk(8'hD5, 2'd1, 16'h000E);
         6'd40: return mk(8'h29, 2'd0, 16'h0000);
         6'd41: return mk(8'h28, 2'd0, 16'h0000);
         6'd42: return mk(8'hB8, 2'd2, 16'h8002);
         6'd43: return mk(8'h10, 2'd0, 16'h0000);
         6'd44: return mk(8'hB0, 2'd1, 16'h0000);
         default: return mk(8'h00, 2'd0, 16'h0000);
      endcase
   endfunction

endpackage

// File: rtl/panel_seq_rom.sv
module panel_seq_rom
   import panel_seq_pkg::*;
(
   input  logic [IDX_W-1:0] idx,
   output seq_entry_t       entry
);

   always_comb entry = seq_lookup(idx);

endmodule

// File: rtl/panel_seq_delay.sv
module panel_seq_delay #(
   parameter int CYCLES = 125000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic expired
);

   localparam int CNT_W = $clog2(CYCLES + 1);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("panel_seq_delay: CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (start)          cnt <= CNT_W'(CYCLES);
      else if (cnt != '0)      cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == CNT_W'(1));

endmodule

// File: rtl/panel_power_seq.sv
module panel_power_seq
   import panel_seq_pkg::*;
#(
   parameter int WAKE_WRITES  = 3,
   parameter int WAKE_DLY_CYC = 125000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en_req,
   input  logic        dis_req,
   output logic        tx_start,
   output logic [7:0]  tx_reg,
   output logic [1:0]  tx_nbytes,
   output logic [15:0] tx_payload,
   input  logic        tx_done,
   input  logic        tx_fail,
   output logic        panel_active,
   output logic        seq_error
);

   localparam int WK_W = $clog2(WAKE_WRITES) + 1;
   localparam logic [WK_W-1:0]  WK_LAST = WK_W'(WAKE_WRITES - 1);
   localparam logic [IDX_W-1:0] UP_LAST = IDX_W'(UP_LEN - 1);
   localparam logic [IDX_W-1:0] DN_LAST = IDX_W'(TBL_LEN - 1);
   localparam logic [IDX_W-1:0] DN_FIRST = IDX_W'(DN_BASE);

   generate
      if (WAKE_WRITES < 1) begin : g_bad_wake
         $error("panel_power_seq: WAKE_WRITES must be at least 1");
      end
   endgenerate

   seq_state_t       state;
   logic [IDX_W-1:0] idx;
   logic [WK_W-1:0]  wk;
   logic             err_acc;
   logic             dly_start, dly_expired;
   seq_entry_t       entry;

   panel_seq_rom u_rom (.idx(idx), .entry(entry));

   assign dly_start = (state == S_WK_WAIT) && tx_done;

   panel_seq_delay #(.CYCLES(WAKE_DLY_CYC)) u_dly (
      .clk(clk), .rst_n(rst_n), .start(dly_start), .expired(dly_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= S_OFF;
         idx          <= '0;
         wk           <= '0;
         err_acc      <= 1'b0;
         panel_active <= 1'b0;
         seq_error    <= 1'b0;
      end else begin
         case (state)
            S_OFF: if (en_req) begin
               err_acc <= 1'b0;
               wk      <= '0;
               state   <= S_WK_ISSUE;
            end
            S_WK_ISSUE: state <= S_WK_WAIT;
            S_WK_WAIT: if (tx_done) begin
               err_acc <= err_acc | tx_fail;
               state   <= S_WK_DLY;
            end
            S_WK_DLY: if (dly_expired) begin
               if (wk == WK_LAST) begin
                  if (err_acc) begin
                     seq_error <= 1'b1;
                     state     <= S_OFF;
                  end else begin
                     idx   <= '0;
                     state <= S_UP_ISSUE;
                  end
               end else begin
                  wk    <= wk + 1'b1;
                  state <= S_WK_ISSUE;
               end
            end
            S_UP_ISSUE: state <= S_UP_WAIT;
            S_UP_WAIT: if (tx_done) begin
               if (idx == UP_LAST) begin
                  panel_active <= 1'b1;
                  seq_error    <= err_acc | tx_fail;
                  state        <= S_ON;
               end else begin
                  err_acc <= err_acc | tx_fail;
                  idx     <= idx + 1'b1;
                  state   <= S_UP_ISSUE;
               end
            end
            S_ON: if (dis_req) begin
               err_acc <= 1'b0;
               idx     <= DN_FIRST;
               state   <= S_DN_ISSUE;
            end
            S_DN_ISSUE: state <= S_DN_WAIT;
            S_DN_WAIT: if (tx_done) begin
               if (idx == DN_LAST) begin
                  panel_active <= 1'b0;
                  seq_error    <= err_acc | tx_fail;
                  state        <= S_OFF;
               end else begin
                  err_acc <= err_acc | tx_fail;
                  idx     <= idx + 1'b1;
                  state   <= S_DN_ISSUE;
               end
            end
            default: state <= S_OFF;
         endcase
      end
   end

   always_comb begin
      tx_start = (state == S_WK_ISSUE) || (state == S_UP_ISSUE) ||
                 (state == S_DN_ISSUE);
      if ((state == S_WK_ISSUE) || (state == S_WK_WAIT) || (state == S_WK_DLY)) begin
         tx_reg     = 8'h00;
         tx_nbytes  = 2'd0;
         tx_payload = 16'h0000;
      end else begin
         tx_reg     = entry.reg_addr;
         tx_nbytes  = entry.nbytes;
         tx_payload = entry.value;
      end
   end

endmodule

// File: rtl/panel_seq_chk.sv
module panel_seq_chk #(
   parameter int DLY = 125000
) (
   input logic        clk,
   input logic        rst_n,
   input logic        tx_start,
   input logic        tx_done,
   input logic [7:0]  tx_reg,
   input logic [1:0]  tx_nbytes,
   input logic [15:0] tx_payload,
   input logic        panel_active
);

   logic        pend;
   logic        after_wake;
   logic [31:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend       <= 1'b0;
         after_wake <= 1'b0;
         gap        <= '0;
      end else begin
         if (tx_start)     pend <= 1'b1;
         else if (tx_done) pend <= 1'b0;
         if (tx_done)       after_wake <= (tx_reg == 8'h00) && (tx_nbytes == 2'd0);
         else if (tx_start) after_wake <= 1'b0;
         if (tx_done)                 gap <= '0;
         else if (gap != 32'hFFFF_FFFF) gap <= gap + 1'b1;
      end
   end

   // R3
   one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start);

   // R3
   single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> !pend);

   // R3
   stable_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> ($stable(tx_reg) && $stable(tx_nbytes) && $stable(tx_payload)));

   // R2
   wake_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_start && after_wake) |-> (gap >= 32'(DLY)));

   // R6
   active_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(panel_active) |-> ($past(tx_done) && $past(tx_reg) == 8'h29 &&
                               $past(tx_nbytes) == 2'd0));

   // R8
   active_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(panel_active) |-> ($past(tx_done) && $past(tx_reg) == 8'hB0 &&
                               $past(tx_nbytes) == 2'd1));

endmodule

bind panel_power_seq panel_seq_chk #(.DLY(WAKE_DLY_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_done(tx_done),
   .tx_reg(tx_reg), .tx_nbytes(tx_nbytes), .tx_payload(tx_payload),
   .panel_active(panel_active)
);

// File: tb/tb_panel_power_seq.sv
module tb_panel_power_seq;

   localparam int DLY = 20;
   localparam int LAT = 3;
   localparam int NWK = 3;

   localparam logic [25:0] EXP [45] = '{
      {8'hB0,2'd1,16'h0017}, {8'hBC,2'd1,16'h0080}, {8'h3B,2'd1,16'h0000},
      {8'hB0,2'd1,16'h0016}, {8'hB8,2'd2,16'hFFF9}, {8'h11,2'd0,16'h0000},
      {8'hBA,2'd1,16'h0001}, {8'hBB,2'd1,16'h0000}, {8'h3A,2'd1,16'h0060},
      {8'hBF,2'd1,16'h0010}, {8'hB1,2'd1,16'h0056}, {8'hB2,2'd1,16'h0033},
      {8'hB3,2'd1,16'h0011}, {8'hB3,2'd1,16'h0011}, {8'hB4,2'd1,16'h0002},
      {8'hB5,2'd1,16'h002B}, {8'hB6,2'd1,16'h0040}, {8'hB7,2'd1,16'h0003},
      {8'hB9,2'd1,16'h0004}, {8'hBD,2'd1,16'h0004}, {8'hBE,2'd1,16'h0000},
      {8'hC0,2'd1,16'h0011}, {8'hC1,2'd1,16'h0011}, {8'hC2,2'd1,16'h0011},
      {8'hC3,2'd2,16'h2040}, {8'hC4,2'd2,16'h60C0}, {8'hC5,2'd2,16'h1020},
      {8'hC6,2'd2,16'h60C0}, {8'hC7,2'd2,16'h5533}, {8'hC8,2'd1,16'h0000},
      {8'hC9,2'd1,16'h0000}, {8'hCA,2'd1,16'h0000}, {8'hEC,2'd2,16'h01F0},
      {8'hCF,2'd1,16'h0002}, {8'hD0,2'd2,16'h0804}, {8'hD1,2'd1,16'h0001},
      {8'hD2,2'd2,16'h0000}, {8'hD3,2'd2,16'h0D0E}, {8'hD4,2'd2,16'h11A4},
      {8'hD5,2'd1,16'h000E}, {8'h29,2'd0,16'h0000},
      {8'h28,2'd0,16'h0000}, {8'hB8,2'd2,16'h8002}, {8'h10,2'd0,16'h0000},
      {8'hB0,2'd1,16'h0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_req = 1'b0, dis_req = 1'b0;
   logic        tx_start;
   logic [7:0]  tx_reg;
   logic [1:0]  tx_nbytes;
   logic [15:0] tx_payload;
   logic        tx_done = 1'b0, tx_fail = 1'b0;
   logic        panel_active, seq_error;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int n_log = 0, cur = 0, lat = 0, fail_at = -1;
   bit pend = 1'b0;
   logic [25:0] lg [64];
   int st_cyc [64];
   int dn_cyc [64];

   panel_power_seq #(.WAKE_WRITES(NWK), .WAKE_DLY_CYC(DLY)) dut (
      .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
      .tx_start(tx_start), .tx_reg(tx_reg), .tx_nbytes(tx_nbytes),
      .tx_payload(tx_payload), .tx_done(tx_done), .tx_fail(tx_fail),
      .panel_active(panel_active), .seq_error(seq_error)
   );

   always #4 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_fail++;
         $display("FAIL R3 watchdog expired act=%0d exp=%0d", cyc, 100000);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   // Writer model, sampled and driven between clock edges
   always @(negedge clk) begin
      tx_done = 1'b0;
      tx_fail = 1'b0;
      if (pend) begin
         lat--;
         if (lat == 0) begin
            tx_done = 1'b1;
            tx_fail = (cur == fail_at);
            dn_cyc[cur] = cyc;
            pend = 1'b0;
         end
      end
      if (tx_start && rst_n) begin
         cur = n_log;
         if (n_log < 64) begin
            lg[n_log] = {tx_reg, tx_nbytes, tx_payload};
            st_cyc[n_log] = cyc;
            n_log++;
         end
         pend = 1'b1;
         lat = LAT;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic pulse_en();
      @(negedge clk); en_req = 1'b1;
      @(negedge clk); en_req = 1'b0;
   endtask

   task automatic pulse_dis();
      @(negedge clk); dis_req = 1'b1;
      @(negedge clk); dis_req = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      settle(3);
      // R1 reset state
      chk(panel_active == 1'b0, "R1", "active after reset", panel_active, 0);
      chk(seq_error == 1'b0, "R1", "error after reset", seq_error, 0);
      chk(tx_start == 1'b0, "R1", "tx_start in reset", tx_start, 0);
      @(negedge clk); rst_n = 1'b1;
      settle(2);
      chk(tx_start == 1'b0, "R1", "tx_start after reset", tx_start, 0);

      // R9 disable while off
      n_log = 0;
      pulse_dis();
      settle(20);
      chk(n_log == 0, "R9", "writes on disable while off", n_log, 0);
      chk(panel_active == 1'b0, "R9", "active on disable while off", panel_active, 0);

      // Clean power-up: R2, R5, R6, R7/R10
      n_log = 0; fail_at = -1;
      pulse_en();
      for (int w = 0; w < 2000 && n_log < NWK + 41; w++) @(negedge clk);
      chk(panel_active == 1'b0, "R6", "active before last done", panel_active, 0);
      settle(600);
      chk(n_log == NWK + 41, "R5", "power-up write count", n_log, NWK + 41);
      for (int i = 0; i < NWK; i++) begin
         chk(lg[i] == 26'd0, "R2", "wake-up write", lg[i], 0);
         chk(st_cyc[i+1] - dn_cyc[i] >= DLY, "R2", "wake-up delay",
             st_cyc[i+1] - dn_cyc[i], DLY);
      end
      for (int i = 0; i < 41; i++)
         chk(lg[NWK+i] == EXP[i], "R5", $sformatf("config write %0d", i),
             lg[NWK+i], EXP[i]);
      chk(panel_active == 1'b1, "R6", "active after power-up", panel_active, 1);
      chk(seq_error == 1'b0, "R10", "error after clean power-up", seq_error, 0);

      // R9 enable while active
      n_log = 0;
      pulse_en();
      settle(20);
      chk(n_log == 0, "R9", "writes on enable while active", n_log, 0);
      chk(panel_active == 1'b1, "R9", "active on enable while active", panel_active, 1);

      // R8 power-down
      n_log = 0;
      pulse_dis();
      settle(100);
      chk(n_log == 4, "R8", "power-down write count", n_log, 4);
      for (int i = 0; i < 4; i++)
         chk(lg[i] == EXP[41+i], "R8", $sformatf("shutdown write %0d", i),
             lg[i], EXP[41+i]);
      chk(panel_active == 1'b0, "R8", "active after power-down", panel_active, 0);

      // R4 wake-up failure aborts
      n_log = 0; fail_at = 1;
      pulse_en();
      settle(600);
      chk(n_log == NWK, "R4", "writes after wake failure", n_log, NWK);
      chk(panel_active == 1'b0, "R4", "active after wake failure", panel_active, 0);
      chk(seq_error == 1'b1, "R4", "error after wake failure", seq_error, 1);

      // R7 configuration failure does not stop
      n_log = 0; fail_at = 10;
      pulse_en();
      settle(600);
      chk(n_log == NWK + 41, "R7", "writes with config failure", n_log, NWK + 41);
      chk(lg[NWK+40] == EXP[40], "R7", "last write with config failure",
          lg[NWK+40], EXP[40]);
      chk(panel_active == 1'b1, "R7", "active with config failure", panel_active, 1);
      chk(seq_error == 1'b1, "R7", "error with config failure", seq_error, 1);

      // R10 clean power-down clears the error
      n_log = 0; fail_at = -1;
      pulse_dis();
      settle(100);
      chk(seq_error == 1'b0, "R10", "error after clean power-down", seq_error, 0);
      chk(panel_active == 1'b0, "R8", "active after second power-down", panel_active, 0);

      // R9 requests during a running sequence are ignored
      n_log = 0;
      pulse_en();
      settle(30);
      pulse_dis();
      pulse_en();
      settle(600);
      chk(n_log == NWK + 41, "R9", "writes with mid-sequence requests", n_log, NWK + 41);
      chk(panel_active == 1'b1, "R9", "active with mid-sequence requests", panel_active, 1);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule